// File: doc/BRIEF.md
# Header Field Alias Reader

This block gives a processor single-access reads of individual IPv4 and IPv6 header fields, whether or not those fields line up with byte or word boundaries. Packet headers are kept in a small on-chip word memory inside the block. Each supported field is given its own alias number.

A read request carries an alias number. A lookup derives two things from the alias:

- which of the two header base registers applies (IPv4 or IPv6);
- the word offset of the field within the header.

The block adds that offset to the selected base and reads the addressed 32-bit word from the memory. One cycle later, a one-hot decoder enables the single field unit that belongs to the alias. That unit shifts and masks the word, and the field comes out zero-extended to 32 bits.

A raw mode returns the whole containing word instead of the isolated field. Headers are loaded through a plain word write port. The two base registers can be changed at run time, so several headers held in the memory can be visited in turn.

Top module: `hdrfld_read_unit`

## Requirements
- R1: `rd_valid` is high in exactly the cycle after each cycle in which `rd_req` was high, and low otherwise; after reset `rd_valid`, `rd_err` and `rd_data` are 0.
- R2: IPv4 aliases 00h..04h read IPv4 word 0 and return these bit ranges of it: 00h bits 31:28, 01h bits 27:24, 02h bits 23:16, 03h bits 31:16, 04h bits 15:0.
- R3: IPv4 aliases 05h..08h read IPv4 word 1 and return: 05h bits 31:16, 06h bits 15:13, 07h bits 12:0, 08h bits 15:0.
- R4: IPv4 aliases 09h..0Ch read IPv4 word 2 and return: 09h bits 31:24, 0Ah bits 23:16, 0Bh bits 31:16, 0Ch bits 15:0.
- R5: IPv6 aliases 0Dh..12h return: 0Dh word 0 bits 31:28, 0Eh word 0 bits 27:20, 0Fh word 0 bits 19:0, 10h word 1 bits 31:16, 11h word 1 bits 15:8, 12h word 1 bits 7:0.
- R6: The word read is memory location (base + word offset) modulo the memory depth (64 words by default). The base is the IPv4 register for aliases 00h..0Ch and the IPv6 register for aliases 0Dh..12h.
- R7: Every returned field is zero-extended: all result bits above the field width are 0.
- R8: For a valid in-range read, exactly one field unit is enabled.
- R9: With `rd_raw` high, an in-range alias returns its whole containing word unchanged.
- R10: After reset the IPv4 base is 0808h and the IPv6 base is 0C00h. A cycle with `base_we` high loads `base_din` into the IPv6 base when `base_v6` is 1, and into the IPv4 base otherwise.
- R11: An alias above 12h returns `rd_data` = 0 with `rd_err` = 1, in both field mode and raw mode.
- R12: A cycle with `wr_en` high stores `wr_data` at memory location `wr_addr` modulo the memory depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Memory word write strobe |
| wr_addr | input | ADDR_W (16) | Memory word write address |
| wr_data | input | 32 | Memory word write data |
| base_we | input | 1 | Base register load strobe |
| base_v6 | input | 1 | Selects the IPv6 (1) or IPv4 (0) base register for loading |
| base_din | input | ADDR_W (16) | New base address |
| rd_req | input | 1 | Field read request |
| rd_alias | input | ALIAS_W (8) | Field alias number |
| rd_raw | input | 1 | Return the whole containing word instead of the field |
| rd_valid | output | 1 | Read result valid, one cycle after the request |
| rd_data | output | 32 | Zero-extended field, raw word, or 0 on error |
| rd_err | output | 1 | Alias out of range |

## Verification
Some properties are checked on every cycle:

- the one-cycle request-to-valid timing;
- that at most one field unit is enabled, and exactly one on an in-range read;
- that field results carry no bits above the field width;
- that an error result is always zero.

Other behaviour can only be shown by the bench's scenarios, which compare each result with values computed from known header words:

- the bit ranges picked for each alias;
- which base register applies;
- the memory address arithmetic, including wrap-around modulo the depth;
- base register reloads;
- raw mode;
- back-to-back requests.

// File: rtl/hdrfld_pkg.sv
package hdrfld_pkg;

    localparam int WORD_W     = 32;
    localparam int NUM_FIELDS = 19;
    localparam int LAST_ALIAS = NUM_FIELDS - 1;
    localparam int FW_W       = $clog2(WORD_W + 1);
    localparam int LSB_W      = $clog2(WORD_W);

    // Placement of one field inside the header
    typedef struct packed {
        logic             v6;      // uses the IPv6 base register
        logic [1:0]       woff;    // word offset from the base
        logic [LSB_W-1:0] lsb;     // lowest bit of the field in the word
        logic [FW_W-1:0]  width;   // field width in bits
    } fld_desc_t;

    function automatic fld_desc_t mk(input logic v6, input int woff,
                                     input int msb, input int lsb);
        fld_desc_t d;
        d.v6    = v6;
        d.woff  = 2'(woff);
        d.lsb   = LSB_W'(lsb);
        d.width = FW_W'(msb - lsb + 1);
        return d;
    endfunction

    function automatic fld_desc_t fld_desc(input int idx);
        case (idx)
            0:  return mk(1'b0, 0, 31, 28);
            1:  return mk(1'b0, 0, 27, 24);
            2:  return mk(1'b0, 0, 23, 16);
            3:  return mk(1'b0, 0, 31, 16);
            4:  return mk(1'b0, 0, 15, 0);
            5:  return mk(1'b0, 1, 31, 16);
            6:  return mk(1'b0, 1, 15, 13);
            7:  return mk(1'b0, 1, 12, 0);
            8:  return mk(1'b0, 1, 15, 0);
            9:  return mk(1'b0, 2, 31, 24);
            10: return mk(1'b0, 2, 23, 16);
            11: return mk(1'b0, 2, 31, 16);
            12: return mk(1'b0, 2, 15, 0);
            13: return mk(1'b1, 0, 31, 28);
            14: return mk(1'b1, 0, 27, 20);
            15: return mk(1'b1, 0, 19, 0);
            16: return mk(1'b1, 1, 31, 16);
            17: return mk(1'b1, 1, 15, 8);
            18: return mk(1'b1, 1, 7, 0);
            default: return mk(1'b0, 0, 31, 0);
        endcase
    endfunction

endpackage

// File: rtl/hdrfld_addr_gen.sv
module hdrfld_addr_gen
    import hdrfld_pkg::*;
#(
    parameter int              ADDR_W  = 16,
    parameter int              ALIAS_W = 8,
    parameter logic [ADDR_W-1:0] V4_BASE = 16'h0808,
    parameter logic [ADDR_W-1:0] V6_BASE = 16'h0C00
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               base_we,
    input  logic               base_v6,
    input  logic [ADDR_W-1:0]  base_din,
    input  logic [ALIAS_W-1:0] alias_i,
    output logic [ADDR_W-1:0]  addr_o
);

    logic [ADDR_W-1:0] base_v4_q;
    logic [ADDR_W-1:0] base_v6_q;
    fld_desc_t         desc;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_v4_q <= V4_BASE;
            base_v6_q <= V6_BASE;
        end else if (base_we) begin
            if (base_v6) base_v6_q <= base_din;
            else         base_v4_q <= base_din;
        end
    end

    always_comb begin
        desc   = fld_desc(int'(alias_i));
        addr_o = (desc.v6 ? base_v6_q : base_v4_q) + ADDR_W'(desc.woff);
    end

endmodule

// File: rtl/hdrfld_mem.sv
module hdrfld_mem
    import hdrfld_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_word
);

    localparam int DEPTH = 1 << MEM_AW;

    logic [WORD_W-1:0] store [DEPTH];
    logic [MEM_AW-1:0] wr_idx;
    logic [MEM_AW-1:0] rd_idx;

    assign wr_idx = MEM_AW'(wr_addr);
    assign rd_idx = MEM_AW'(rd_addr);

    always_ff @(posedge clk) begin
        if (wr_en) store[wr_idx] <= wr_data;
        if (rd_en) rd_word <= store[rd_idx];
    end

endmodule

// File: rtl/hdrfld_extract.sv
module hdrfld_extract
    import hdrfld_pkg::*;
#(
    parameter int ALIAS_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               valid_i,
    input  logic [ALIAS_W-1:0] alias_i,
    input  logic               raw_i,
    input  logic [WORD_W-1:0]  word_i,
    output logic [WORD_W-1:0]  data_o,
    output logic               err_o
);

    logic [NUM_FIELDS-1:0] en;
    logic [WORD_W-1:0]     part [NUM_FIELDS];
    logic [WORD_W-1:0]     field;
    logic                  out_range;

    assign out_range = (int'(alias_i) > LAST_ALIAS);

    // one-hot decoder and per-field shift/mask units
    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_unit
        localparam fld_desc_t D = fld_desc(i);
        assign en[i] = valid_i && !raw_i && (int'(alias_i) == i);
        if (int'(D.width) == WORD_W) begin : g_pass
            assign part[i] = en[i] ? word_i : '0;
        end else begin : g_cut
            localparam logic [WORD_W-1:0] MASK = WORD_W'((64'd1 << D.width) - 64'd1);
            assign part[i] = en[i] ? ((word_i >> D.lsb) & MASK) : '0;
        end
    end

    always_comb begin
        field = '0;
        for (int i = 0; i < NUM_FIELDS; i++) field |= part[i];
    end

    always_comb begin
        err_o = valid_i && out_range;
        if (!valid_i || out_range) data_o = '0;
        else if (raw_i)            data_o = word_i;
        else                       data_o = field;
    end

    AST_ONE_UNIT: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !raw_i && !out_range) |-> $countones(en) == 1) else $error("one unit"); // R8
    AST_AT_MOST_ONE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(en)) else $error("multi unit"); // R8
    AST_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !raw_i && !out_range) |->
            ((data_o >> fld_desc(int'(alias_i)).width) == '0)) else $error("zext"); // R7

endmodule

// File: rtl/hdrfld_read_unit.sv
module hdrfld_read_unit
    import hdrfld_pkg::*;
#(
    parameter int              ADDR_W  = 16,
    parameter int              MEM_AW  = 6,
    parameter int              ALIAS_W = 8,
    parameter logic [ADDR_W-1:0] V4_BASE = 16'h0808,
    parameter logic [ADDR_W-1:0] V6_BASE = 16'h0C00
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic               base_we,
    input  logic               base_v6,
    input  logic [ADDR_W-1:0]  base_din,
    input  logic               rd_req,
    input  logic [ALIAS_W-1:0] rd_alias,
    input  logic               rd_raw,
    output logic               rd_valid,
    output logic [WORD_W-1:0]  rd_data,
    output logic               rd_err
);

    logic [ADDR_W-1:0]  rd_addr;
    logic [WORD_W-1:0]  mem_word;
    logic               valid_q;
    logic [ALIAS_W-1:0] alias_q;
    logic               raw_q;

    hdrfld_addr_gen #(
        .ADDR_W (ADDR_W),
        .ALIAS_W(ALIAS_W),
        .V4_BASE(V4_BASE),
        .V6_BASE(V6_BASE)
    ) u_addr (
        .clk     (clk),
        .rst     (rst),
        .base_we (base_we),
        .base_v6 (base_v6),
        .base_din(base_din),
        .alias_i (rd_alias),
        .addr_o  (rd_addr)
    );

    hdrfld_mem #(
        .ADDR_W(ADDR_W),
        .MEM_AW(MEM_AW)
    ) u_mem (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_en  (rd_req),
        .rd_addr(rd_addr),
        .rd_word(mem_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            alias_q <= '0;
            raw_q   <= 1'b0;
        end else begin
            valid_q <= rd_req;
            if (rd_req) begin
                alias_q <= rd_alias;
                raw_q   <= rd_raw;
            end
        end
    end

    hdrfld_extract #(
        .ALIAS_W(ALIAS_W)
    ) u_ext (
        .clk    (clk),
        .rst    (rst),
        .valid_i(valid_q),
        .alias_i(alias_q),
        .raw_i  (raw_q),
        .word_i (mem_word),
        .data_o (rd_data),
        .err_o  (rd_err)
    );

    assign rd_valid = valid_q;

    AST_REQ_TO_VALID: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_valid) else $error("late valid"); // R1
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rd_valid) else $error("spurious valid"); // R1
    AST_ERR_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_err |-> (rd_valid && rd_data == '0)) else $error("err data"); // R11

endmodule

// File: tb/tb_hdrfld_read_unit.sv
module tb_hdrfld_read_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [15:0] wr_addr;
    logic [31:0] wr_data;
    logic        base_we;
    logic        base_v6;
    logic [15:0] base_din;
    logic        rd_req;
    logic [7:0]  rd_alias;
    logic        rd_raw;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        rd_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    typedef struct {
        logic [31:0] data;
        logic        err;
        string       tag;
    } exp_t;
    exp_t sb [$];

    always #10 clk = ~clk;

    hdrfld_read_unit dut (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .base_we(base_we), .base_v6(base_v6), .base_din(base_din),
        .rd_req(rd_req), .rd_alias(rd_alias), .rd_raw(rd_raw),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err)
    );

    // header words used by the model
    logic [31:0] v4w [3];
    logic [31:0] v6w [2];

    function automatic logic [31:0] model(input int a);
        case (a)
            0:  return {28'd0, v4w[0][31:28]};
            1:  return {28'd0, v4w[0][27:24]};
            2:  return {24'd0, v4w[0][23:16]};
            3:  return {16'd0, v4w[0][31:16]};
            4:  return {16'd0, v4w[0][15:0]};
            5:  return {16'd0, v4w[1][31:16]};
            6:  return {29'd0, v4w[1][15:13]};
            7:  return {19'd0, v4w[1][12:0]};
            8:  return {16'd0, v4w[1][15:0]};
            9:  return {24'd0, v4w[2][31:24]};
            10: return {24'd0, v4w[2][23:16]};
            11: return {16'd0, v4w[2][31:16]};
            12: return {16'd0, v4w[2][15:0]};
            13: return {28'd0, v6w[0][31:28]};
            14: return {24'd0, v6w[0][27:20]};
            15: return {12'd0, v6w[0][19:0]};
            16: return {16'd0, v6w[1][31:16]};
            17: return {24'd0, v6w[1][15:8]};
            default: return {24'd0, v6w[1][7:0]};
        endcase
    endfunction

    function automatic logic [31:0] raw_model(input int a);
        case (a)
            0, 1, 2, 3, 4:  return v4w[0];
            5, 6, 7, 8:     return v4w[1];
            9, 10, 11, 12:  return v4w[2];
            13, 14, 15:     return v6w[0];
            default:        return v6w[1];
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic mem_write(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_base(input bit v6, input logic [15:0] b);
        @(negedge clk);
        base_we = 1'b1; base_v6 = v6; base_din = b;
        @(negedge clk);
        base_we = 1'b0;
    endtask

    // driver: one request per call, back to back when called in a row
    task automatic read(input int a, input bit raw, input string tag);
        exp_t e;
        @(negedge clk);
        rd_req = 1'b1; rd_alias = 8'(a); rd_raw = raw;
        if (a > 18) begin e.data = 32'd0; e.err = 1'b1; end
        else begin e.data = raw ? raw_model(a) : model(a); e.err = 1'b0; end
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    // monitor: compare every result against the scoreboard
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R1 unexpected valid", {31'd0, rd_valid}, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(rd_data === e.data, e.tag, rd_data, e.data);
                check(rd_err === e.err, {e.tag, " R11 err flag"}, {31'd0, rd_err}, {31'd0, e.err});
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 0; wr_addr = 0; wr_data = 0;
        base_we = 0; base_v6 = 0; base_din = 0;
        rd_req = 0; rd_alias = 0; rd_raw = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(rd_valid === 1'b0, "R1 reset valid", {31'd0, rd_valid}, 0);
        check(rd_err === 1'b0, "R1 reset err", {31'd0, rd_err}, 0);
        check(rd_data === 32'd0, "R1 reset data", rd_data, 0);

        // R12 load headers: default bases 0808h -> word 8, 0C00h -> word 0
        v4w[0] = 32'h45B8_05DC; v4w[1] = 32'hBEEF_A5A5; v4w[2] = 32'h4011_C3D2;
        v6w[0] = 32'h6ABC_DEF1; v6w[1] = 32'h0400_3A40;
        mem_write(16'h0008, v4w[0]);
        mem_write(16'h0009, v4w[1]);
        mem_write(16'h000A, v4w[2]);
        mem_write(16'h0000, v6w[0]);
        mem_write(16'h0001, v6w[1]);

        // R2 R3 R4 R5 R10: every alias, back to back, at default bases
        for (int a = 0; a < 19; a++) begin
            string t;
            if (a < 5)       t = $sformatf("R2 alias %0d", a);
            else if (a < 9)  t = $sformatf("R3 alias %0d", a);
            else if (a < 13) t = $sformatf("R4 alias %0d", a);
            else             t = $sformatf("R5 R10 alias %0d", a);
            read(a, 1'b0, t);
        end
        idle();

        // R9 raw mode
        read(3, 1'b1, "R9 raw v4 w0");
        read(7, 1'b1, "R9 raw v4 w1");
        read(15, 1'b1, "R9 raw v6 w0");
        read(18, 1'b1, "R9 raw v6 w1");
        idle();

        // R11 out of range aliases
        read(19, 1'b0, "R11 alias 13h");
        read(255, 1'b0, "R11 alias FFh");
        read(19, 1'b1, "R11 raw alias 13h");
        idle();

        // R7 all-ones words: zero extension visible in upper bits
        v4w[0] = 32'hFFFF_FFFF; v4w[1] = 32'hFFFF_FFFF; v4w[2] = 32'hFFFF_FFFF;
        mem_write(16'h0020, v4w[0]);
        mem_write(16'h0021, v4w[1]);
        mem_write(16'h0022, v4w[2]);
        // R10 move IPv4 base to 0020h
        set_base(1'b0, 16'h0020);
        read(0, 1'b0, "R7 R10 ver ones");
        read(6, 1'b0, "R7 R10 flags ones");
        read(7, 1'b0, "R7 R10 frag ones");
        read(9, 1'b0, "R7 R10 ttl ones");
        read(11, 1'b0, "R7 R10 half ones");
        idle();
        // R10 IPv6 base still at default, unaffected by IPv4 reload
        read(16, 1'b0, "R10 v6 unaffected");
        idle();

        // R6 wrap: IPv6 base 003Fh, word 1 lands at location 0 modulo 64
        v6w[0] = 32'h7123_4567; v6w[1] = 32'h89AB_CDEF;
        mem_write(16'h003F, v6w[0]);
        mem_write(16'h0000, v6w[1]);
        set_base(1'b1, 16'h103F);
        read(13, 1'b0, "R6 wrap word0");
        read(15, 1'b0, "R6 wrap word0 flow");
        read(17, 1'b0, "R6 wrap word1");
        read(18, 1'b0, "R6 wrap word1 hop");
        idle();

        // R12 overwrite and reread
        v4w[1] = 32'h1234_4321;
        mem_write(16'h0021, v4w[1]);
        read(5, 1'b0, "R12 R3 rewrite ident");
        read(8, 1'b0, "R12 R3 rewrite half");
        idle();

        // R1 valid drops after the last request
        @(negedge clk);
        check(rd_valid === 1'b0, "R1 idle valid", {31'd0, rd_valid}, 0);
        repeat (2) @(negedge clk);
        check(sb.size() == 0, "R1 all results seen", sb.size(), 0);

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule